// File: doc/BRIEF.md
# Exponential Backoff Delay Generator

This block tells a requester how long to stall after it loses a compare-and-swap race. It keeps a backoff count that starts at one. Each reported failure produces one pause request, and the count then doubles for the next failure. Doubling stops once the count has grown past a configured limit. A reported success returns the count to one.

The pause length is requested in cycles. It is the count multiplied by 128, which is a left shift by seven bits. The whole amount goes out in a single request rather than as a string of short ones. A downstream pause timer takes the request through a valid/ready handshake.

Top module: `backoff_delay_gen`

## Requirements
- R1: After reset no request is pending and the count is one, so the first accepted failure requests 128 cycles.
- R2: A failure pulse seen while no request is pending raises `pause_valid` on the next cycle. `pause_cycles` then equals the count at the time of the pulse shifted left by 7 bits.
- R3: After each accepted failure the count doubles, so successive requests carry 128, 256, 512 and so on. The doubling takes effect only after the amount for that failure has been captured.
- R4: Doubling is skipped when the count is strictly greater than 4096. The count therefore settles at 8192, and every later request carries 1048576 cycles. Neither the 14-bit count nor the 21-bit amount overflows.
- R5: While `pause_valid` is high and `pause_ready` is low, the request and its amount stay unchanged. `pause_valid` falls on the cycle after the one in which `pause_ready` is seen high.
- R6: A failure pulse that arrives while a request is pending is ignored. It leaves both the pending amount and the count unchanged.
- R7: A success pulse resets the count to one and drops any pending request on the next cycle. A success pulse takes priority over a failure pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attempt_fail | input | 1 | One-cycle pulse: the atomic attempt failed |
| attempt_success | input | 1 | One-cycle pulse: the atomic attempt succeeded |
| pause_valid | output | 1 | A pause request is pending |
| pause_ready | input | 1 | The pause timer takes the request |
| pause_cycles | output | 21 | Requested pause length in cycles |

## Verification
Each result appears exactly one clock edge after the pulse or handshake that causes it. After an accepted failure, `pause_valid` and `pause_cycles` are new on the next cycle. After a handshake or a success pulse, `pause_valid` is low on the next cycle. The count shows up only in the amount of the following request, so R3, R4 and R6 are judged from that amount. The bench drives its inputs after the falling edge. It advances a behavioural model at each rising edge and compares both outputs with the model at the next falling edge, once that edge has settled the registers.

// File: rtl/bk_pkg.sv
package bk_pkg;
    localparam int unsigned BK_CNT_W   = 14;
    localparam int unsigned BK_SHIFT   = 7;
    localparam int unsigned BK_LIMIT   = 4096;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_WAIT = 1'b1
    } req_state_e;
endpackage

// File: rtl/bk_count.sv
module bk_count #(
    parameter int unsigned CNT_W = bk_pkg::BK_CNT_W,
    parameter int unsigned LIMIT = bk_pkg::BK_LIMIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = ONE;
        end else if (accept && !(r_q.cnt > LIMIT_V)) begin
            r_d.cnt = {r_q.cnt[CNT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{cnt: ONE};
        else        r_q <= r_d;
    end

    assign count_o = r_q.cnt;

    // R4: the count never goes past twice the limit
    assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= (LIMIT_V << 1));
    // R4: once the count is past the limit, it holds
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && r_q.cnt > LIMIT_V) |=> $stable(r_q.cnt));
    // R3: the count stays a power of two
    assert_cnt_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(r_q.cnt));
    // R7: a clear brings the count back to one
    assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (r_q.cnt == ONE));
endmodule

// File: rtl/bk_req.sv
module bk_req
    import bk_pkg::*;
#(
    parameter int unsigned CNT_W = BK_CNT_W,
    parameter int unsigned SHIFT = BK_SHIFT,
    localparam int unsigned AMT_W = CNT_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [CNT_W-1:0] count_i,
    input  logic             ready,
    output logic             valid_o,
    output logic [AMT_W-1:0] amt_o
);
    typedef struct packed {
        req_state_e       st;
        logic [AMT_W-1:0] amt;
    } req_reg_t;

    req_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.st = REQ_IDLE;
        end else begin
            unique case (r_q.st)
                REQ_IDLE: if (accept) begin
                    r_d.st  = REQ_WAIT;
                    r_d.amt = {count_i, {SHIFT{1'b0}}};
                end
                REQ_WAIT: if (ready) r_d.st = REQ_IDLE;
                default:  r_d.st = REQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: REQ_IDLE, amt: '0};
        else        r_q <= r_d;
    end

    assign valid_o = (r_q.st == REQ_WAIT);
    assign amt_o   = r_q.amt;

    // R5: a request that is not taken holds its amount
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready && !clear) |=> (valid_o && $stable(amt_o)));
    // R5: a handshake ends the request
    assert_req_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready) |=> !valid_o);
endmodule

// File: rtl/backoff_delay_gen.sv
module backoff_delay_gen #(
    parameter int unsigned CNT_W = bk_pkg::BK_CNT_W,
    parameter int unsigned SHIFT = bk_pkg::BK_SHIFT,
    parameter int unsigned LIMIT = bk_pkg::BK_LIMIT,
    localparam int unsigned AMT_W = CNT_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             attempt_fail,
    input  logic             attempt_success,
    output logic             pause_valid,
    input  logic             pause_ready,
    output logic [AMT_W-1:0] pause_cycles
);
    logic             accept;
    logic [CNT_W-1:0] count;

    // a failure counts only when nothing is pending and no success wins
    assign accept = attempt_fail && !attempt_success && !pause_valid;

    bk_count #(.CNT_W(CNT_W), .LIMIT(LIMIT)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (attempt_success),
        .accept  (accept),
        .count_o (count)
    );

    bk_req #(.CNT_W(CNT_W), .SHIFT(SHIFT)) i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (attempt_success),
        .accept  (accept),
        .count_i (count),
        .ready   (pause_ready),
        .valid_o (pause_valid),
        .amt_o   (pause_cycles)
    );

    // R2: a failure with nothing pending raises a request
    assert_fail_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt_fail && !attempt_success && !pause_valid) |=> pause_valid);
    // R6: a failure while pending leaves the amount alone
    assert_fail_ign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid && attempt_fail && !attempt_success) |=> $stable(pause_cycles));
    // R7: a success drops the request
    assert_succ_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        attempt_success |=> !pause_valid);
endmodule

// File: tb/test_backoff_delay_gen.sv
`timescale 1ns/1ps
module test_backoff_delay_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fail_i = 1'b0;
    logic        succ_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        valid_o;
    logic [20:0] cyc_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural model
    int  m_cnt = 1;
    bit  m_valid = 0;
    int  m_amt = 0;

    always #2.5 clk = ~clk;

    backoff_delay_gen i_backoff_delay_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .attempt_fail    (fail_i),
        .attempt_success (succ_i),
        .pause_valid     (valid_o),
        .pause_ready     (ready_i),
        .pause_cycles    (cyc_o)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic check(input string tag);
        n_run++;
        if (valid_o !== m_valid) begin
            n_fail++;
            $display("FAIL %s: pause_valid got %0b expected %0b", tag, valid_o, m_valid);
        end else if (m_valid && cyc_o !== m_amt[20:0]) begin
            n_fail++;
            $display("FAIL %s: pause_cycles got %0d expected %0d", tag, cyc_o, m_amt);
        end
    endtask

    // one clock: model advances at the rising edge, compare at the falling edge
    task automatic step(input string tag);
        bit old_v;
        @(posedge clk);
        old_v = m_valid;
        if (!rst_n) begin
            m_cnt = 1; m_valid = 0;
        end else if (succ_i) begin
            m_cnt = 1; m_valid = 0;
        end else begin
            if (old_v && ready_i) m_valid = 0;
            if (fail_i && !old_v) begin
                m_amt = m_cnt * 128;
                m_valid = 1;
                if (m_cnt <= 4096) m_cnt = m_cnt * 2;
            end
        end
        @(negedge clk);
        check(tag);
        fail_i = 0; succ_i = 0;
    endtask

    task automatic fail_and_take(input string tag);
        fail_i = 1; ready_i = 1;
        step(tag);
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        report();
    end

    initial begin
        step("R1 reset");
        step("R1 reset");
        rst_n = 1;
        step("R1 idle after reset");
        // R1 R2: first request is 128
        fail_and_take("R2 first amount");
        // R3: doubling sequence
        for (int k = 0; k < 4; k++) fail_and_take("R3 doubling");
        // R5: hold while ready low; R6: extra fail ignored
        ready_i = 0; fail_i = 1;
        step("R5 request raised");
        for (int k = 0; k < 4; k++) begin
            fail_i = (k % 2 == 0);
            step("R6 fail while pending");
        end
        step("R5 hold");
        ready_i = 1;
        step("R5 handshake");
        ready_i = 0;
        step("R5 idle after handshake");
        fail_and_take("R6 count unchanged by ignored fail");
        // R4: drive to saturation and beyond
        for (int k = 0; k < 12; k++) fail_and_take("R4 saturation");
        // R7: success drops pending request and resets count
        ready_i = 0; fail_i = 1;
        step("R7 request before success");
        succ_i = 1;
        step("R7 success drops request");
        fail_and_take("R7 count back to one");
        // R7: success beats a failure in the same cycle
        fail_i = 1; succ_i = 1; ready_i = 1;
        step("R7 success wins over fail");
        fail_and_take("R7 count after tie");
        fail_and_take("R3 doubling after reset");
        done = 1;
        report();
    end
endmodule